// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

The block moves data between two 18-bit buses, A and B, one path per direction. Each path keeps one storage cell. That cell can act as a transparent latch, hold its value, or capture on a falling edge of a per-direction data clock. Each direction has a latch enable, a data clock and an output enable. The A-to-B output enable is active high; the B-to-A output enable is active low.

The block is synchronous to a system clock. It registers every control and data input once. It finds falling edges of the data clocks by comparing two successive samples. Each bus side is a plain input vector, an output vector and a per-bit drive-enable vector; tri-state pins are not used. A drive-enable bit of 0 means the bit is high impedance.

Top module: `ubx_transceiver`

## Requirements
- R1: With its latch enable high, a path is transparent. The output shows the input sampled on the previous system-clock edge, so the latency is one cycle.
- R2: With the latch enable low and the data clock held at a steady level, the output keeps its stored value when the input data changes.
- R3: With the latch enable low, a 1-to-0 change of the data clock captures the input. The data is taken from the same edge that first sees the clock low, and it appears on the output one edge later. A 0-to-1 change of the data clock captures nothing.
- R4: The A-to-B output enable is active high. When it is 0, every bit of `b_drv` is 0 and `b_out` is all zeros. When it is 1, every bit of `b_drv` is 1.
- R5: The B-to-A path behaves the same way, using `ba_le` and `ba_dclk`. Its enable `ba_oe_n` is active low: a 1 makes every bit of `a_drv` 0 and `a_out` zero.
- R6: If the latch enable falls while the data clock is low and the clock then stays low, the output keeps the value it showed just before the latch enable fell.
- R7: All 18 bits of a path share that direction's controls; each bit position carries its own input bit.
- R8: After reset both stored values are zero. A data clock held high through reset and after it produces no capture.
- R9: In transparent mode the storage loads on every cycle. A switch to hold keeps the last value that passed through.
- R10: If both output enables are active, both sides drive at once. The block does not arbitrate and only flags the condition with a warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 18 | Data read from bus A |
| b_in | input | 18 | Data read from bus B |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_dclk | input | 1 | A-to-B data clock, captures on falling edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_dclk | input | 1 | B-to-A data clock, captures on falling edge |
| b_out | output | 18 | Value driven onto bus B |
| b_drv | output | 18 | Per-bit drive enable for bus B |
| a_out | output | 18 | Value driven onto bus A |
| a_drv | output | 18 | Per-bit drive enable for bus A |

## Verification
The assertions check three things on every cycle. A transparent or capturing cycle loads the registered input into the cell. Any other cycle leaves the cell unchanged. A disabled direction drives no bit one cycle after its enable goes inactive. Only the bench scenarios can show the behaviour that depends on a sequence of events. These include the exact latency from a falling data-clock edge to the output, and the fact that a rising edge captures nothing. They also include the value kept when the latch enable falls with the clock low, and the absence of a false edge after reset with the clock held high.

// File: rtl/ubx_pkg.sv
// Package: shared width and data type for the bus transceiver.
// Assumes both buses have the same width.
package ubx_pkg;
    parameter int BUS_W = 18;
    typedef logic [BUS_W-1:0] bus_t;
endpackage

// File: rtl/ubx_fall_det.sv
// Falling-edge detector for a data clock sampled by the system clock.
// Assumes the data clock is slow compared with clk; the previous sample
// resets to 0, so a clock held high through reset gives no edge.
module ubx_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_in,
    output logic fall
);
    logic cur_q;
    logic prev_q;

    // Keep the current and previous samples of the data clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            cur_q  <= dclk_in;
            prev_q <= cur_q;
        end
    end

    // An edge is the previous sample high and the current sample low.
    assign fall = prev_q & ~cur_q;
endmodule

// File: rtl/ubx_path_cell.sv
// One direction of the transceiver: input register, latch/flip-flop cell
// and output select. Assumes all bits share le and dclk. Latency from
// input to output is one cycle (transparent), or one cycle after a
// detected falling edge (clocked).
module ubx_path_cell #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         le,
    input  logic         dclk,
    output logic [W-1:0] val_out
);
    logic [W-1:0] data_q;
    logic         le_q;
    logic         fall;
    logic [W-1:0] store;

    ubx_fall_det u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .dclk_in (dclk),
        .fall    (fall)
    );

    // Register data and latch enable alongside the data-clock samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            le_q   <= 1'b0;
        end else begin
            data_q <= din;
            le_q   <= le;
        end
    end

    // Storage cell: load when transparent or on a falling data-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            store <= '0;
        else if (le_q || fall)
            store <= data_q;
    end

    // Output: live registered data when transparent, stored value otherwise.
    assign val_out = le_q ? data_q : store;

    assert_transparent_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        le_q |=> (store == $past(data_q)));
    assert_edge_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !le_q) |=> (store == $past(data_q)));
    assert_hold_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_q && !fall) |=> $stable(store));
endmodule

// File: rtl/ubx_transceiver.sv
// Bidirectional 18-bit bus transceiver with two independent paths.
// Each bus side has an output vector and a per-bit drive enable instead of
// tri-state pins. Enables are registered so they line up with the data.
// Nothing arbitrates between the two directions.
module ubx_transceiver #(
    parameter int W = ubx_pkg::BUS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_oe,
    input  logic         ab_le,
    input  logic         ab_dclk,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_dclk,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_drv,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_drv
);
    logic [W-1:0] ab_val;
    logic [W-1:0] ba_val;
    logic         ab_en_q;
    logic         ba_en_q;

    ubx_path_cell #(.W(W)) u_ab (
        .clk (clk), .rst_n (rst_n), .din (a_in),
        .le (ab_le), .dclk (ab_dclk), .val_out (ab_val)
    );

    ubx_path_cell #(.W(W)) u_ba (
        .clk (clk), .rst_n (rst_n), .din (b_in),
        .le (ba_le), .dclk (ba_dclk), .val_out (ba_val)
    );

    // Register both enables, converting them to active-high form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ab_en_q <= 1'b0;
            ba_en_q <= 1'b0;
        end else begin
            ab_en_q <= ab_oe;
            ba_en_q <= ~ba_oe_n;
        end
    end

    // Drive each side from its path, zeroed when the direction is disabled.
    assign b_drv = {W{ab_en_q}};
    assign a_drv = {W{ba_en_q}};
    assign b_out = ab_en_q ? ab_val : '0;
    assign a_out = ba_en_q ? ba_val : '0;

    assert_b_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_oe |=> (b_drv == '0 && b_out == '0));
    assert_a_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ba_oe_n |=> (a_drv == '0 && a_out == '0));
    assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ab_en_q && ba_en_q))
        else $warning("both bus directions driving at once");
endmodule

// File: tb/sim_ubx_transceiver.sv
module sim_ubx_transceiver;
    localparam int W = 18;
    logic clk = 1'b0;
    logic rst_n;
    logic [W-1:0] a_in, b_in;
    logic ab_oe, ab_le, ab_dclk, ba_oe_n, ba_le, ba_dclk;
    logic [W-1:0] b_out, b_drv, a_out, a_drv;
    int n_chk = 0;
    int n_bad = 0;
    localparam logic [W-1:0] ONES = '1;

    always #2.5 clk = ~clk;

    ubx_transceiver #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_dclk(ab_dclk),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_dclk(ba_dclk),
        .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
    );

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // R8: reset clears storage; a data clock held high makes no edge.
    task automatic t_reset();
        rst_n = 1'b0; a_in = '1; b_in = '1;
        ab_oe = 1'b1; ab_le = 1'b0; ab_dclk = 1'b1;
        ba_oe_n = 1'b1; ba_le = 1'b0; ba_dclk = 1'b1;
        step(3);
        rst_n = 1'b1;
        step(4);
        check("R8 b_out after reset", b_out, '0);
        check("R8 b_drv enabled", b_drv, ONES);
        check("R5 a_drv disabled", a_drv, '0);
    endtask

    // R1, R7: transparent path under several patterns.
    task automatic t_transparent();
        logic [W-1:0] pats [4] = '{18'h2AAAA, 18'h15555, 18'h00001, 18'h20000};
        ab_dclk = 1'b0; ab_le = 1'b1;
        foreach (pats[i]) begin
            a_in = pats[i];
            step(1);
            check("R1 R7 transparent follow", b_out, pats[i]);
        end
    endtask

    // R9, R2, R3: switch to hold, rising edge ignored, falling edge captures.
    task automatic t_hold_capture();
        a_in = 18'h0F0F0; step(1);
        ab_le = 1'b0; a_in = 18'h3C3C3; step(3);
        check("R9 last transparent value held", b_out, 18'h0F0F0);
        ab_dclk = 1'b1; step(3);
        check("R3 rising edge no capture", b_out, 18'h0F0F0);
        a_in = 18'h12345; ab_dclk = 1'b0; step(1);
        check("R3 not yet visible", b_out, 18'h0F0F0);
        step(1);
        check("R3 falling edge capture", b_out, 18'h12345);
        a_in = 18'h3FFFF; step(4);
        check("R2 hold with clock low", b_out, 18'h12345);
    endtask

    // R6: latch enable falls while the data clock is low.
    task automatic t_le_fall_low();
        ab_dclk = 1'b0; ab_le = 1'b1; a_in = 18'h0ABCD; step(1);
        ab_le = 1'b0; a_in = 18'h35432; step(4);
        check("R6 value before latch enable fell", b_out, 18'h0ABCD);
    endtask

    // R4: output enable of A-to-B path, active high.
    task automatic t_ab_oe();
        ab_oe = 1'b0; step(1);
        check("R4 b_drv off", b_drv, '0);
        check("R4 b_out zero", b_out, '0);
        ab_oe = 1'b1; step(1);
        check("R4 b_drv on", b_drv, ONES);
        check("R4 stored value kept", b_out, 18'h0ABCD);
    endtask

    // R5: B-to-A path with active-low enable.
    task automatic t_ba();
        ab_oe = 1'b0; ba_oe_n = 1'b0; ba_dclk = 1'b0;
        ba_le = 1'b1; b_in = 18'h1E1E1; step(1);
        check("R5 a_drv on", a_drv, ONES);
        check("R5 transparent", a_out, 18'h1E1E1);
        ba_le = 1'b0; ba_dclk = 1'b1; b_in = 18'h0777F; step(3);
        check("R5 hold", a_out, 18'h1E1E1);
        ba_dclk = 1'b0; step(2);
        check("R5 falling edge capture", a_out, 18'h0777F);
        ba_oe_n = 1'b1; step(1);
        check("R5 a_drv off", a_drv, '0);
        check("R5 a_out zero", a_out, '0);
    endtask

    // R10: both enables active, both sides drive.
    task automatic t_both();
        ab_oe = 1'b1; ba_oe_n = 1'b0; step(1);
        check("R10 b_drv", b_drv, ONES);
        check("R10 a_drv", a_drv, ONES);
        ba_oe_n = 1'b1; step(1);
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_hold_capture();
        t_le_fall_low();
        t_ab_oe();
        t_ba();
        t_both();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule